// File: doc/BRIEF.md
# Parallel DAC Write Sequencer

This block takes 12-bit samples from a valid/ready handshake and writes each one into the input latch of a parallel multiplying digital-to-analog converter. The latch is level sensitive. It passes its data bus through while both active-low strobes, chip-select and write, are low. It holds its contents once either strobe is high. The sequencer drives the strobes and the bus so that every minimum interval at the latch is respected: chip-select lead before write, write pulse width, data setup to the write rising edge, and data hold after it.

All intervals are whole clock cycles. The cycle counts are derived at elaboration from the clock period and from nanosecond minimums for two supply modes. The mode is chosen per sample by an input that is captured when the sample is accepted. A bipolar input, also captured at acceptance, turns a two's-complement sample into the offset-binary code the converter expects.

The sequence for each sample is fixed. The word goes onto the bus first, with both strobes high. Chip-select then falls, write pulses low and rises again, and chip-select is released last. A new sample is taken only after chip-select has returned high.

Top module: `pdac_write_seq`

## Requirements
- R1: After reset, and whenever no write is in progress, `sampleReady` is 1 and both strobes are high. A sample is accepted on a clock edge where `sampleValid` and `sampleReady` are both 1.
- R2: Once a sample is accepted, `sampleReady` stays 0 until chip-select has gone high again. While a write is in progress, `sampleValid` and `sampleData` have no effect on the bus. A second write begins only after the first write's chip-select has risen.
- R3: The bus takes the new word at least one clock before chip-select falls. The bus does not change while chip-select is low, so an unsettled word is never passed through the latch.
- R4: The time from chip-select falling to write falling is at least 380 ns with `hiSupply`=0, and at least 200 ns with `hiSupply`=1.
- R5: Write stays low for at least 400 ns (`hiSupply`=0) or 240 ns (`hiSupply`=1). The bus is stable for at least 210 ns (`hiSupply`=0) or 120 ns (`hiSupply`=1) before write rises.
- R6: Write is low only while chip-select is low, and chip-select rises no earlier than write. The bus holds its value for at least 10 ns after write rises.
- R7: With `bipolarMode`=1 the written code is the sample with bit 11 (the MSB) inverted and bits 10..0 unchanged, so 0x7FF becomes 0xFFF and 0x800 becomes 0x000. With `bipolarMode`=0 the sample is written unchanged.
- R8: After each write, a transparent latch model fed by the strobes and the bus holds the expected code. It keeps holding that code when the bus later changes while chip-select is high.
- R9: While reset is asserted, chip-select and write are high and the bus is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | A sample is offered |
| sampleReady | output | 1 | The sequencer is idle and takes the offered sample |
| sampleData | input | 12 | Sample, bit 11 is the MSB |
| bipolarMode | input | 1 | 1: two's-complement sample, converted to offset binary |
| hiSupply | input | 1 | 1: high-supply timing minimums, 0: low-supply minimums |
| dacCsN | output | 1 | Active-low chip-select to the converter latch |
| dacWrN | output | 1 | Active-low write strobe to the converter latch |
| dacBus | output | 12 | Parallel data bus to the converter latch |

## Verification
The bench measures every strobe and bus edge in time and compares each interval against the nanosecond minimum of the mode in use. A sequencer that sized a count for the wrong mode, or dropped a cycle from a count, would fail these checks. The bench also holds `sampleValid` high across a write while it changes the data. A design that took a sample while busy, or that let the bus change while chip-select was low, would leave the wrong word in the latch model or move the bus early. The bipolar corner codes 0x7FF, 0x800, 0x000 and 0xFFF catch an inversion applied to the wrong bit or to all bits. The bench also checks that the latch keeps the old code when the next word appears on the bus with chip-select high.

// File: rtl/pdac_pkg.sv
`timescale 1ns/1ps
package pdac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRIVE,
    ST_CS_LEAD,
    ST_WR_START,
    ST_WR_LOW,
    ST_WR_RELEASE,
    ST_HOLD,
    ST_CS_RELEASE
  } seq_state_e;

  typedef struct packed {
    logic load;
    logic csLow;
    logic wrLow;
    logic modeHi;
  } pdac_strobe_t;

  function automatic int nsToCycles(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pdac_seq_ctrl.sv
`timescale 1ns/1ps
module pdac_seq_ctrl
  import pdac_pkg::*;
#(
  parameter int CLK_PERIOD_NS  = 10,
  parameter int CS_LEAD_LO_NS  = 380,
  parameter int WR_WIDTH_LO_NS = 400,
  parameter int DSETUP_LO_NS   = 210,
  parameter int DHOLD_LO_NS    = 10,
  parameter int CS_HOLD_LO_NS  = 0,
  parameter int CS_LEAD_HI_NS  = 200,
  parameter int WR_WIDTH_HI_NS = 240,
  parameter int DSETUP_HI_NS   = 120,
  parameter int DHOLD_HI_NS    = 10,
  parameter int CS_HOLD_HI_NS  = 0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleValid,
  input  logic         hiSupply,
  output logic         sampleReady,
  output pdac_strobe_t strobes
);

  localparam int CS_CYC_LO   = nsToCycles(CS_LEAD_LO_NS, CLK_PERIOD_NS);
  localparam int CS_CYC_HI   = nsToCycles(CS_LEAD_HI_NS, CLK_PERIOD_NS);
  localparam int WR_CYC_LO   = maxOf(nsToCycles(WR_WIDTH_LO_NS, CLK_PERIOD_NS),
                                     nsToCycles(DSETUP_LO_NS, CLK_PERIOD_NS));
  localparam int WR_CYC_HI   = maxOf(nsToCycles(WR_WIDTH_HI_NS, CLK_PERIOD_NS),
                                     nsToCycles(DSETUP_HI_NS, CLK_PERIOD_NS));
  localparam int HOLD_CYC_LO = maxOf(nsToCycles(DHOLD_LO_NS, CLK_PERIOD_NS),
                                     nsToCycles(CS_HOLD_LO_NS, CLK_PERIOD_NS));
  localparam int HOLD_CYC_HI = maxOf(nsToCycles(DHOLD_HI_NS, CLK_PERIOD_NS),
                                     nsToCycles(CS_HOLD_HI_NS, CLK_PERIOD_NS));
  localparam int MAX_CYC     = maxOf(maxOf(maxOf(CS_CYC_LO, CS_CYC_HI),
                                           maxOf(WR_CYC_LO, WR_CYC_HI)),
                                     maxOf(HOLD_CYC_LO, HOLD_CYC_HI));
  localparam int CNT_W       = $clog2(MAX_CYC + 1);

  seq_state_e       state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             modeHiQ;
  logic             accept;
  logic [CNT_W-1:0] csLoad, wrLoad, holdLoad;

  assign accept      = sampleValid && (state == ST_IDLE);
  assign sampleReady = (state == ST_IDLE);

  assign csLoad   = modeHiQ ? CNT_W'(CS_CYC_HI - 1)   : CNT_W'(CS_CYC_LO - 1);
  assign wrLoad   = modeHiQ ? CNT_W'(WR_CYC_HI - 1)   : CNT_W'(WR_CYC_LO - 1);
  assign holdLoad = modeHiQ ? CNT_W'(HOLD_CYC_HI - 1) : CNT_W'(HOLD_CYC_LO - 1);

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    case (state)
      ST_IDLE:       if (sampleValid) stateNext = ST_DRIVE;
      ST_DRIVE: begin
        stateNext = ST_CS_LEAD;
        cntNext   = csLoad;
      end
      ST_CS_LEAD:    if (cnt == '0) stateNext = ST_WR_START;
                     else cntNext = cnt - CNT_W'(1);
      ST_WR_START: begin
        stateNext = ST_WR_LOW;
        cntNext   = wrLoad;
      end
      ST_WR_LOW:     if (cnt == '0) stateNext = ST_WR_RELEASE;
                     else cntNext = cnt - CNT_W'(1);
      ST_WR_RELEASE: begin
        stateNext = ST_HOLD;
        cntNext   = holdLoad;
      end
      ST_HOLD:       if (cnt == '0) stateNext = ST_CS_RELEASE;
                     else cntNext = cnt - CNT_W'(1);
      ST_CS_RELEASE: stateNext = ST_IDLE;
      default:       stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      modeHiQ <= 1'b0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
      if (accept) modeHiQ <= hiSupply;
    end
  end

  always_comb begin
    strobes.load   = accept;
    strobes.modeHi = modeHiQ;
    strobes.wrLow  = (state == ST_WR_START) || (state == ST_WR_LOW);
    strobes.csLow  = (state == ST_CS_LEAD) || strobes.wrLow ||
                     (state == ST_WR_RELEASE) || (state == ST_HOLD);
  end

endmodule

// File: rtl/pdac_datapath.sv
`timescale 1ns/1ps
module pdac_datapath
  import pdac_pkg::*;
#(
  parameter int DATA_W         = 12,
  parameter bit BIPOLAR_EN     = 1'b1,
  parameter int CLK_PERIOD_NS  = 10,
  parameter int CS_LEAD_LO_NS  = 380,
  parameter int WR_WIDTH_LO_NS = 400,
  parameter int DSETUP_LO_NS   = 210,
  parameter int DHOLD_LO_NS    = 10,
  parameter int CS_LEAD_HI_NS  = 200,
  parameter int WR_WIDTH_HI_NS = 240,
  parameter int DSETUP_HI_NS   = 120,
  parameter int DHOLD_HI_NS    = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  pdac_strobe_t      strobes,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              bipolarMode,
  output logic              dacCsN,
  output logic              dacWrN,
  output logic [DATA_W-1:0] dacBus
);

  localparam int MSB   = DATA_W - 1;
  localparam int CHK_W = 16;

  logic [DATA_W-1:0] codeIn;

  generate
    if (BIPOLAR_EN) begin : g_bipolar
      assign codeIn = {sampleData[MSB] ^ bipolarMode, sampleData[MSB-1:0]};
    end else begin : g_unipolar
      assign codeIn = sampleData;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacCsN <= 1'b1;
      dacWrN <= 1'b1;
      dacBus <= '0;
    end else begin
      dacCsN <= !strobes.csLow;
      dacWrN <= !strobes.wrLow;
      if (strobes.load) dacBus <= codeIn;
    end
  end

  // Interval checking: saturating age counters observed by the assertions.
  logic [CHK_W-1:0]  ageCs, ageWr, ageWrHi, ageBus;
  logic [DATA_W-1:0] busPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ageCs   <= '0;
      ageWr   <= '0;
      ageWrHi <= '0;
      ageBus  <= '0;
      busPrev <= '0;
    end else begin
      busPrev <= dacBus;
      ageCs   <= dacCsN ? '0 : ((&ageCs) ? ageCs : ageCs + 1'b1);
      ageWr   <= dacWrN ? '0 : ((&ageWr) ? ageWr : ageWr + 1'b1);
      ageWrHi <= !dacWrN ? '0 : ((&ageWrHi) ? ageWrHi : ageWrHi + 1'b1);
      ageBus  <= (dacBus != busPrev) ? '0 : ((&ageBus) ? ageBus : ageBus + 1'b1);
    end
  end

  int needCs, needWr, needDs, needDh;
  assign needCs = strobes.modeHi ? CS_LEAD_HI_NS  : CS_LEAD_LO_NS;
  assign needWr = strobes.modeHi ? WR_WIDTH_HI_NS : WR_WIDTH_LO_NS;
  assign needDs = strobes.modeHi ? DSETUP_HI_NS   : DSETUP_LO_NS;
  assign needDh = strobes.modeHi ? DHOLD_HI_NS    : DHOLD_LO_NS;

  AST_WR_NESTED: assert property (@(posedge clk) disable iff (!rstN)
    !dacWrN |-> !dacCsN); // R6
  AST_BUS_STABLE_CS: assert property (@(posedge clk) disable iff (!rstN)
    !dacCsN |-> $stable(dacBus)); // R3
  AST_DATA_BEFORE_CS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dacCsN) |-> $stable(dacBus)); // R3
  AST_CS_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dacWrN) |-> (int'(ageCs) * CLK_PERIOD_NS >= needCs)); // R4
  AST_WR_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dacWrN) |-> (int'(ageWr) * CLK_PERIOD_NS >= needWr)); // R5
  AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dacWrN) |-> (int'(ageBus) * CLK_PERIOD_NS >= needDs)); // R5
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dacBus) |-> (dacWrN && int'(ageWrHi) * CLK_PERIOD_NS >= needDh)); // R6
  AST_MSB_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && bipolarMode) |=> (dacBus[MSB] != $past(sampleData[MSB]))); // R7

endmodule

// File: rtl/pdac_write_seq.sv
`timescale 1ns/1ps
module pdac_write_seq
  import pdac_pkg::*;
#(
  parameter int DATA_W         = 12,
  parameter bit BIPOLAR_EN     = 1'b1,
  parameter int CLK_PERIOD_NS  = 10,
  parameter int CS_LEAD_LO_NS  = 380,
  parameter int WR_WIDTH_LO_NS = 400,
  parameter int DSETUP_LO_NS   = 210,
  parameter int DHOLD_LO_NS    = 10,
  parameter int CS_HOLD_LO_NS  = 0,
  parameter int CS_LEAD_HI_NS  = 200,
  parameter int WR_WIDTH_HI_NS = 240,
  parameter int DSETUP_HI_NS   = 120,
  parameter int DHOLD_HI_NS    = 10,
  parameter int CS_HOLD_HI_NS  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  output logic              sampleReady,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              bipolarMode,
  input  logic              hiSupply,
  output logic              dacCsN,
  output logic              dacWrN,
  output logic [DATA_W-1:0] dacBus
);

  pdac_strobe_t strobes;

  pdac_seq_ctrl #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .CS_LEAD_LO_NS (CS_LEAD_LO_NS),  .WR_WIDTH_LO_NS(WR_WIDTH_LO_NS),
    .DSETUP_LO_NS  (DSETUP_LO_NS),   .DHOLD_LO_NS   (DHOLD_LO_NS),
    .CS_HOLD_LO_NS (CS_HOLD_LO_NS),
    .CS_LEAD_HI_NS (CS_LEAD_HI_NS),  .WR_WIDTH_HI_NS(WR_WIDTH_HI_NS),
    .DSETUP_HI_NS  (DSETUP_HI_NS),   .DHOLD_HI_NS   (DHOLD_HI_NS),
    .CS_HOLD_HI_NS (CS_HOLD_HI_NS)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .hiSupply    (hiSupply),
    .sampleReady (sampleReady),
    .strobes     (strobes)
  );

  pdac_datapath #(
    .DATA_W        (DATA_W),
    .BIPOLAR_EN    (BIPOLAR_EN),
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .CS_LEAD_LO_NS (CS_LEAD_LO_NS),  .WR_WIDTH_LO_NS(WR_WIDTH_LO_NS),
    .DSETUP_LO_NS  (DSETUP_LO_NS),   .DHOLD_LO_NS   (DHOLD_LO_NS),
    .CS_LEAD_HI_NS (CS_LEAD_HI_NS),  .WR_WIDTH_HI_NS(WR_WIDTH_HI_NS),
    .DSETUP_HI_NS  (DSETUP_HI_NS),   .DHOLD_HI_NS   (DHOLD_HI_NS)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .sampleData  (sampleData),
    .bipolarMode (bipolarMode),
    .dacCsN      (dacCsN),
    .dacWrN      (dacWrN),
    .dacBus      (dacBus)
  );

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    sampleReady |-> (dacCsN && dacWrN)); // R1
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (sampleReady && sampleValid) |=> !sampleReady); // R2

endmodule

// File: tb/pdac_latch_model.sv
`timescale 1ns/1ps
module pdac_latch_model #(
  parameter int W = 12
) (
  input  logic         rstN,
  input  logic         csN,
  input  logic         wrN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_latch begin
    if (!rstN)              q = '0;
    else if (!csN && !wrN)  q = d;
  end

endmodule

// File: tb/sim_pdac_write_seq.sv
`timescale 1ns/1ps
module sim_pdac_write_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic        sampleReady;
  logic [11:0] sampleData = '0;
  logic        bipolarMode = 1'b0;
  logic        hiSupply = 1'b0;
  logic        dacCsN, dacWrN;
  logic [11:0] dacBus;
  logic [11:0] latchQ;

  int nChecks = 0;
  int nFails  = 0;

  time tCsFall = 0, tCsRise = 0, tWrFall = 0, tWrRise = 0, tBus = 0;

  always #5 clk = ~clk;

  pdac_write_seq u0 (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleReady(sampleReady),
    .sampleData(sampleData), .bipolarMode(bipolarMode), .hiSupply(hiSupply),
    .dacCsN(dacCsN), .dacWrN(dacWrN), .dacBus(dacBus)
  );

  pdac_latch_model #(.W(12)) uLatch (
    .rstN(rstN), .csN(dacCsN), .wrN(dacWrN), .d(dacBus), .q(latchQ)
  );

  always @(negedge dacCsN) tCsFall = $time;
  always @(posedge dacCsN) tCsRise = $time;
  always @(negedge dacWrN) tWrFall = $time;
  always @(posedge dacWrN) tWrRise = $time;
  always @(dacBus)         tBus    = $time;

  // {hiSupply, bipolarMode, sample, expected code}
  localparam int NVEC = 8;
  localparam logic [25:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 12'hABC, 12'hABC},
    {1'b1, 1'b0, 12'h001, 12'h001},
    {1'b0, 1'b1, 12'h7FF, 12'hFFF},
    {1'b1, 1'b1, 12'h800, 12'h000},
    {1'b0, 1'b1, 12'h000, 12'h800},
    {1'b1, 1'b1, 12'hFFF, 12'h7FF},
    {1'b0, 1'b0, 12'hFFF, 12'hFFF},
    {1'b1, 1'b0, 12'h000, 12'h000}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
               req, what, act, act, expv, expv);
    end
  endtask

  task automatic checkWrite(input logic hi, input logic [11:0] expCode);
    longint csNeed, wrNeed, dsNeed;
    csNeed = hi ? 200 : 380;
    wrNeed = hi ? 240 : 400;
    dsNeed = hi ? 120 : 210;
    check(latchQ == expCode, "R8", "latched code", latchQ, expCode);
    check(latchQ == expCode, "R7", "converted code", latchQ, expCode);
    check(tBus < tCsFall, "R3", "bus settled before cs falls (bus time vs cs time)",
          tBus, tCsFall);
    check(tWrFall - tCsFall >= csNeed, "R4", "cs to wr lead ns", tWrFall - tCsFall, csNeed);
    check(tWrRise - tWrFall >= wrNeed, "R5", "wr low width ns", tWrRise - tWrFall, wrNeed);
    check(tWrRise - tBus >= dsNeed, "R5", "data setup ns", tWrRise - tBus, dsNeed);
    check(tCsRise - tWrRise >= 10, "R6", "data hold / cs after wr ns",
          tCsRise - tWrRise, 10);
  endtask

  task automatic runWrite(input logic hi, input logic bip, input logic [11:0] s,
                          input logic [11:0] expCode);
    @(negedge clk);
    check(sampleReady && dacCsN && dacWrN, "R1", "ready while idle", sampleReady, 1);
    hiSupply    = hi;
    bipolarMode = bip;
    sampleData  = s;
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    wait (dacCsN == 1'b0);
    @(negedge clk);
    check(!sampleReady, "R2", "ready low while busy", sampleReady, 0);
    wait (dacCsN == 1'b1);
    @(negedge clk);
    checkWrite(hi, expCode);
  endtask

  initial begin
    #1_500_000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    time tRiseA;
    // Reset state, R9
    repeat (3) @(negedge clk);
    check(dacCsN && dacWrN, "R9", "strobes high in reset", {dacCsN, dacWrN}, 3);
    check(dacBus == 12'h000, "R9", "bus zero in reset", dacBus, 0);
    check(latchQ == 12'h000, "R9", "latch zero in reset", latchQ, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(sampleReady == 1'b1, "R1", "ready after reset", sampleReady, 1);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      runWrite(VECS[i][25], VECS[i][24], VECS[i][23:12], VECS[i][11:0]);
    end

    // Back-to-back with valid held and data changed while busy (R2, R8)
    @(negedge clk);
    hiSupply    = 1'b1;
    bipolarMode = 1'b0;
    sampleData  = 12'h5A5;
    sampleValid = 1'b1;
    @(negedge clk);
    sampleData  = 12'h3C3;
    wait (dacCsN == 1'b0);
    @(negedge clk);
    check(!sampleReady, "R2", "ready low with valid held", sampleReady, 0);
    check(dacBus == 12'h5A5, "R2", "busy-time data ignored", dacBus, 12'h5A5);
    wait (dacCsN == 1'b1);
    tRiseA = tCsRise;
    @(negedge clk);
    check(latchQ == 12'h5A5, "R8", "first word latched", latchQ, 12'h5A5);
    @(negedge clk);
    check(dacBus == 12'h3C3 && dacCsN, "R3", "next word on bus with cs high", dacBus, 12'h3C3);
    check(latchQ == 12'h5A5, "R8", "latch holds while bus changes, cs high", latchQ, 12'h5A5);
    sampleValid = 1'b0;
    wait (dacCsN == 1'b0);
    check(tCsFall > tRiseA, "R2", "second cs fall after first cs rise", tCsFall, tRiseA);
    wait (dacCsN == 1'b1);
    @(negedge clk);
    checkWrite(1'b1, 12'h3C3);

    // Bipolar in unipolar mode leaves MSB alone (R7)
    runWrite(1'b0, 1'b0, 12'h800, 12'h800);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule